// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives the six gate signals of a three-phase inverter bridge. The three legs are called A, B and C, and each leg has a high-side and a low-side output. All three legs share one center-aligned timebase, which counts in system clock cycles. Each leg compares the timebase against its own duty value to form a complementary pair. A programmable dead time then delays the turn-on edge of every side, so the two switches of a leg are never on together.

After dead-time insertion each leg can swap its high and low signals. This crossover serves block-commutated drives of brushless and electronically commutated motors. Each of the six outputs has its own enable. A single polarity bit selects active-high or active-low drive.

Software reaches the block through a single-cycle write port. Period, duty and dead-time writes go to shadow copies, and those copies take effect only at the next period boundary.

Top module: `pwm3_gen`

## Requirements
- R1: The timebase value rises from 0 to P and then falls back to 1, where P is the period register (address 0). One PWM period is therefore 2·P clock cycles. For a duty d with 0 < d < P, the raw high side of a leg is active for 2·d−1 cycles per period and the raw low side for the remaining 2·P−2·d+1 cycles.
- R2: The duty registers are at address 1 (leg A), address 2 (leg B) and address 3 (leg C). A duty of 0 keeps the high side off for the whole period. A duty at or above P keeps the high side on for the whole period.
- R3: The dead-time register (address 4) holds a value T. Each side turns on only after its raw signal has been active for T consecutive cycles. This removes T cycles from every active stretch, or the whole stretch if it is shorter than T.
- R4: The high-side and low-side outputs of a leg are never active in the same cycle.
- R5: Control register (address 5) bits 4:2 are the crossover bits for legs C, B and A, with bit 2 for A. When a leg's bit is set, its high-side output carries the low-side signal and its low-side output carries the high-side signal.
- R6: The output-enable register (address 6) has one bit per output: bit 0 hs_a, 1 ls_a, 2 hs_b, 3 ls_b, 4 hs_c, 5 ls_c. An output whose bit is 0 holds the inactive level.
- R7: Control bit 1 selects active-low drive. When it is set, every output pin is inverted, including the inactive level of disabled outputs.
- R8: Control bit 0 runs the block. While it is 0, the timebase is held at 0, the dead-time counters are cleared and all six outputs hold the inactive level. Outputs are registered one cycle after the control state.
- R9: A write to the period, duty or dead-time register takes effect only at the start of the next PWM period. The period already in progress completes with the old values.
- R10: After reset all registers are 0 and all six outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the PWM count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DW | Register write data |
| hs_a | output | 1 | Leg A high-side drive |
| ls_a | output | 1 | Leg A low-side drive |
| hs_b | output | 1 | Leg B high-side drive |
| ls_b | output | 1 | Leg B low-side drive |
| hs_c | output | 1 | Leg C high-side drive |
| ls_c | output | 1 | Leg C low-side drive |

## Verification
The bench builds the block with its defaults: an 8-bit period and duty width, a 4-bit dead time and a 16-bit write word. Periods of 6 to 20 then give PWM periods of only 12 to 40 cycles, so every per-period on-time can be counted exactly over a full period. That includes the case where a dead time longer than the pulse swallows it completely. The 4-bit dead-time counter saturates after 15 cycles, so steady outputs at 0 % and 100 % duty also fall within the short runs.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  // register addresses
  localparam logic [2:0] ADR_PERIOD = 3'd0;
  localparam logic [2:0] ADR_DUTY_A = 3'd1;
  localparam logic [2:0] ADR_DUTY_B = 3'd2;
  localparam logic [2:0] ADR_DUTY_C = 3'd3;
  localparam logic [2:0] ADR_DEAD   = 3'd4;
  localparam logic [2:0] ADR_CTRL   = 3'd5;
  localparam logic [2:0] ADR_OUTEN  = 3'd6;
  // control field positions
  localparam int CB_RUN  = 0;
  localparam int CB_LOWA = 1;
  localparam int CB_XOV  = 2;
  localparam int NLEG    = 3;
  localparam int NOUT    = 2 * NLEG;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int CW  = 8,
  parameter int DTW = 4,
  parameter int DW  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [2:0]               wr_addr,
  input  logic [DW-1:0]            wr_data,
  output logic [CW-1:0]            sh_per,
  output logic [NLEG-1:0][CW-1:0]  sh_duty,
  output logic [DTW-1:0]           sh_dt,
  output logic                     run,
  output logic                     pol,
  output logic [NLEG-1:0]          xov,
  output logic [NOUT-1:0]          oen
);
  logic unused_hi;
  assign unused_hi = ^wr_data[DW-1:CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_per  <= '0;
      sh_duty <= '0;
      sh_dt   <= '0;
      run     <= 1'b0;
      pol     <= 1'b0;
      xov     <= '0;
      oen     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_PERIOD: sh_per     <= wr_data[CW-1:0];
        ADR_DUTY_A: sh_duty[0] <= wr_data[CW-1:0];
        ADR_DUTY_B: sh_duty[1] <= wr_data[CW-1:0];
        ADR_DUTY_C: sh_duty[2] <= wr_data[CW-1:0];
        ADR_DEAD:   sh_dt      <= wr_data[DTW-1:0];
        ADR_CTRL: begin
          run <= wr_data[CB_RUN];
          pol <= wr_data[CB_LOWA];
          xov <= wr_data[CB_XOV+NLEG-1:CB_XOV];
        end
        ADR_OUTEN:  oen        <= wr_data[NOUT-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
  import pwm3_pkg::*;
#(
  parameter int CW  = 8,
  parameter int DTW = 4,
  localparam int TW = CW + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic [CW-1:0]            sh_per,
  input  logic [NLEG-1:0][CW-1:0]  sh_duty,
  input  logic [DTW-1:0]           sh_dt,
  output logic [TW-1:0]            tick,
  output logic [CW-1:0]            tri_v,
  output logic [CW-1:0]            act_per,
  output logic [NLEG-1:0][CW-1:0]  act_duty,
  output logic [DTW-1:0]           act_dt,
  output logic                     wrap
);
  // fold the linear tick into an up/down value
  function automatic logic [CW-1:0] fold(input logic [TW-1:0] t, input logic [CW-1:0] p);
    logic [TW-1:0] d;
    if (t <= {1'b0, p}) d = t;
    else                d = {p, 1'b0} - t;
    return d[CW-1:0];
  endfunction

  logic last;
  assign last  = (act_per == '0) || (tick == ({act_per, 1'b0} - TW'(1)));
  assign wrap  = !run || last;
  assign tri_v = fold(tick, act_per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick     <= '0;
      act_per  <= '0;
      act_duty <= '0;
      act_dt   <= '0;
    end else if (wrap) begin
      tick     <= '0;
      act_per  <= sh_per;
      act_duty <= sh_duty;
      act_dt   <= sh_dt;
    end else begin
      tick <= tick + TW'(1);
    end
  end
endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg #(
  parameter int CW  = 8,
  parameter int DTW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [CW-1:0]  tri_v,
  input  logic [CW-1:0]  per,
  input  logic [CW-1:0]  duty,
  input  logic [DTW-1:0] dt,
  output logic           hi,
  output logic           lo
);
  function automatic logic raw_on(input logic [CW-1:0] t, input logic [CW-1:0] d,
                                  input logic [CW-1:0] p);
    return (d >= p) || (t < d);
  endfunction

  logic [1:0] raw;
  logic [1:0] gated;
  assign raw[0] = raw_on(tri_v, duty, per);
  assign raw[1] = !raw[0];

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [DTW-1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 age <= '0;
      else if (!run || !raw[s])   age <= '0;
      else if (age != '1)         age <= age + DTW'(1);
    end
    assign gated[s] = raw[s] && (age >= dt);
  end

  assign hi = gated[0];
  assign lo = gated[1];
endmodule

// File: rtl/pwm3_outstage.sv
module pwm3_outstage
  import pwm3_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            pol,
  input  logic [NLEG-1:0] xov,
  input  logic [NOUT-1:0] oen,
  input  logic [NLEG-1:0] hi,
  input  logic [NLEG-1:0] lo,
  output logic [NOUT-1:0] pins
);
  logic [NOUT-1:0] act;

  for (genvar i = 0; i < NLEG; i++) begin : g_pair
    logic h_sel, l_sel;
    assign h_sel = xov[i] ? lo[i] : hi[i];
    assign l_sel = xov[i] ? hi[i] : lo[i];
    assign act[2*i]   = run && oen[2*i]   && h_sel;
    assign act[2*i+1] = run && oen[2*i+1] && l_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins <= '0;
    else        pins <= act ^ {NOUT{pol}};
  end
endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
  import pwm3_pkg::*;
#(
  parameter int CW  = 8,
  parameter int DTW = 4,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          hs_a,
  output logic          ls_a,
  output logic          hs_b,
  output logic          ls_b,
  output logic          hs_c,
  output logic          ls_c
);
  localparam int TW = CW + 1;

  logic [CW-1:0]           sh_per, act_per, tri_v;
  logic [NLEG-1:0][CW-1:0] sh_duty, act_duty;
  logic [DTW-1:0]          sh_dt, act_dt;
  logic                    run, pol, wrap_w;
  logic [NLEG-1:0]         xov, hi_w, lo_w;
  logic [NOUT-1:0]         oen, pins;
  logic [TW-1:0]           tick_w;

  pwm3_regs #(.CW(CW), .DTW(DTW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sh_per(sh_per), .sh_duty(sh_duty), .sh_dt(sh_dt),
    .run(run), .pol(pol), .xov(xov), .oen(oen)
  );

  pwm3_timebase #(.CW(CW), .DTW(DTW)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sh_per(sh_per), .sh_duty(sh_duty), .sh_dt(sh_dt),
    .tick(tick_w), .tri_v(tri_v), .act_per(act_per),
    .act_duty(act_duty), .act_dt(act_dt), .wrap(wrap_w)
  );

  for (genvar i = 0; i < NLEG; i++) begin : g_leg
    pwm3_leg #(.CW(CW), .DTW(DTW)) u_leg (
      .clk(clk), .rst_n(rst_n), .run(run), .tri_v(tri_v),
      .per(act_per), .duty(act_duty[i]), .dt(act_dt),
      .hi(hi_w[i]), .lo(lo_w[i])
    );
  end

  pwm3_outstage u_out (
    .clk(clk), .rst_n(rst_n), .run(run), .pol(pol), .xov(xov), .oen(oen),
    .hi(hi_w), .lo(lo_w), .pins(pins)
  );

  assign hs_a = pins[0];
  assign ls_a = pins[1];
  assign hs_b = pins[2];
  assign ls_b = pins[3];
  assign hs_c = pins[4];
  assign ls_c = pins[5];
endmodule

// File: rtl/pwm3_gen_chk.sv
module pwm3_gen_chk
  import pwm3_pkg::*;
#(
  parameter int CW = 8,
  localparam int TW = CW + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    run,
  input logic                    pol,
  input logic [NOUT-1:0]         oen,
  input logic [NOUT-1:0]         pins,
  input logic                    wrap,
  input logic [TW-1:0]           tick,
  input logic [CW-1:0]           act_per,
  input logic [NLEG-1:0][CW-1:0] act_duty
);
  for (genvar i = 0; i < NLEG; i++) begin : g_pair
    // R4
    pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((pins[2*i] ^ $past(pol)) && (pins[2*i+1] ^ $past(pol))));
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_en
    // R6
    out_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oen[k] |=> (pins[k] == $past(pol)));
  end

  // R8
  run_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pins == {NOUT{$past(pol)}}));

  // R9
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_duty));

  // R1
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_per != '0) |-> (tick < {act_per, 1'b0}));
endmodule

bind pwm3_gen pwm3_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pol(pol), .oen(oen), .pins(pins),
  .wrap(wrap_w), .tick(tick_w), .act_per(act_per), .act_duty(act_duty)
);

// File: tb/pwm3_gen_bench.sv
`timescale 1ns/1ps
module pwm3_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic hs_a, ls_a, hs_b, ls_b, hs_c, ls_c;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm3_gen u_pwm3_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .hs_c(hs_c), .ls_c(ls_c)
  );

  typedef struct packed {
    logic [7:0] per;
    logic [7:0] da, db, dc;
    logic [3:0] dt;
    logic [2:0] xov;
    logic [5:0] oen;
    logic       pol;
    logic [7:0] e0, e1, e2, e3, e4, e5;
  } vec_t;

  // expected values: active cycles per 2*P-cycle period, order hs_a ls_a hs_b ls_b hs_c ls_c
  localparam vec_t VECS [6] = '{
    '{8'd10, 8'd4, 8'd0, 8'd10, 4'd2, 3'b000, 6'h3F,      1'b0, 8'd5,  8'd11, 8'd0,  8'd20, 8'd20, 8'd0},
    '{8'd10, 8'd1, 8'd5, 8'd9,  4'd0, 3'b000, 6'h3F,      1'b0, 8'd1,  8'd19, 8'd9,  8'd11, 8'd17, 8'd3},
    '{8'd10, 8'd1, 8'd5, 8'd9,  4'd0, 3'b101, 6'h3F,      1'b0, 8'd19, 8'd1,  8'd9,  8'd11, 8'd3,  8'd17},
    '{8'd8,  8'd3, 8'd6, 8'd2,  4'd1, 3'b000, 6'b101101,  1'b0, 8'd4,  8'd0,  8'd10, 8'd4,  8'd0,  8'd12},
    '{8'd8,  8'd3, 8'd6, 8'd2,  4'd1, 3'b000, 6'b101101,  1'b1, 8'd4,  8'd0,  8'd10, 8'd4,  8'd0,  8'd12},
    '{8'd6,  8'd2, 8'd2, 8'd2,  4'd4, 3'b010, 6'h3F,      1'b0, 8'd0,  8'd5,  8'd5,  8'd0,  8'd0,  8'd5}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [5:0] pinv();
    return {ls_c, hs_c, ls_b, hs_b, ls_a, hs_a};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset outputs", int'(pinv()), 0);

    // R8 / R7: stopped block holds the inactive level of the chosen polarity
    wr(3'd5, 16'h0002);
    repeat (2) @(negedge clk);
    chk("R8 R7 stopped active-low idle", int'(pinv()), 63);
    wr(3'd5, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R8 stopped active-high idle", int'(pinv()), 0);

    // table walk: R1 R2 R3 R4 R5 R6 R7
    foreach (VECS[v]) begin
      int cnt [6];
      int overlap;
      logic [5:0] a;
      wr(3'd0, {8'd0, VECS[v].per});
      wr(3'd1, {8'd0, VECS[v].da});
      wr(3'd2, {8'd0, VECS[v].db});
      wr(3'd3, {8'd0, VECS[v].dc});
      wr(3'd4, {12'd0, VECS[v].dt});
      wr(3'd6, {10'd0, VECS[v].oen});
      wr(3'd5, {11'd0, VECS[v].xov, VECS[v].pol, 1'b1});
      repeat (100) @(negedge clk);
      foreach (cnt[k]) cnt[k] = 0;
      overlap = 0;
      for (int c = 0; c < 2 * int'(VECS[v].per); c++) begin
        @(negedge clk);
        a = pinv() ^ {6{VECS[v].pol}};
        for (int k = 0; k < 6; k++) cnt[k] += int'(a[k]);
        for (int p = 0; p < 3; p++) if (a[2*p] && a[2*p+1]) overlap++;
      end
      chk($sformatf("R1 R2 R3 R5 R6 R7 vec%0d hs_a", v), cnt[0], int'(VECS[v].e0));
      chk($sformatf("R1 R2 R3 R5 R6 R7 vec%0d ls_a", v), cnt[1], int'(VECS[v].e1));
      chk($sformatf("R1 R2 R3 R5 R6 R7 vec%0d hs_b", v), cnt[2], int'(VECS[v].e2));
      chk($sformatf("R1 R2 R3 R5 R6 R7 vec%0d ls_b", v), cnt[3], int'(VECS[v].e3));
      chk($sformatf("R1 R2 R3 R5 R6 R7 vec%0d hs_c", v), cnt[4], int'(VECS[v].e4));
      chk($sformatf("R1 R2 R3 R5 R6 R7 vec%0d ls_c", v), cnt[5], int'(VECS[v].e5));
      chk($sformatf("R4 vec%0d pair overlap", v), overlap, 0);
    end

    // R9: duty write mid-period waits for the next period start
    begin
      int guard;
      int seen;
      wr(3'd0, 16'd20);
      wr(3'd1, 16'd1);
      wr(3'd4, 16'd0);
      wr(3'd6, 16'h003F);
      wr(3'd5, 16'h0001);
      repeat (120) @(negedge clk);
      guard = 0;
      @(negedge clk);
      while (!hs_a && guard < 200) begin
        @(negedge clk);
        guard++;
      end
      chk("R9 period-start pulse found", int'(hs_a), 1);
      wr(3'd1, 16'd20);
      seen = 0;
      for (int c = 0; c < 37; c++) begin
        @(negedge clk);
        seen += int'(hs_a);
      end
      chk("R9 old duty holds to period end", seen, 0);
      @(negedge clk);
      chk("R9 new duty at period start", int'(hs_a), 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule